// File: doc/BRIEF.md
# Motion Counter with Acceleration Scaling

This block counts pointer movement for a serial pointing device. Four direction sensor lines come in already synchronized, one each for up, down, left and right. Every level change on a line adds one step of movement on its axis. Two signed saturating accumulators hold the net horizontal and vertical movement. Three button inputs pass through per-button debounce counters. The debounced button state is always present on an output, so that each movement report goes out with the current buttons.

In stream mode a sample strobe from an external rate timer marks the end of each sample interval. At that strobe the block snapshots both accumulators into the report registers and pulses a valid flag for the packet builder. With acceleration on, each snapshot passes through a stepped magnitude curve that keeps the sign. In remote mode the report registers follow the accumulators continuously, with no scaling. The command handler empties the accumulators with two strobes: one for any command other than a resend, and one when a movement report has gone out. A resend-pending input holds those clears back, so a packet that is being sent again still carries the same movement.

Top module: `mc_motion_top`

## Requirements
- R1: Each cycle in which `sens_rt` differs from its value in the previous cycle adds +1 to the X accumulator, and a change on `sens_lt` adds -1. `sens_up` and `sens_dn` do the same for Y. A change on both opposing lines in the same cycle leaves the axis unchanged. The sensor history is 0 after reset.
- R2: Each accumulator is W-bit two's complement (default 9) and saturates at +255 and -256. A step that would pass a limit leaves the value at the limit and sets the axis overflow flag (`ovf_x`/`ovf_y`). The flag stays set until the accumulator is cleared.
- R3: A debounced button takes a new raw level only after that level has been present for DEB_CYCLES consecutive clock edges. A shorter excursion leaves the debounced state unchanged. This applies to both press and release.
- R4: `btn` bit 0 is the left button, bit 1 the right button and bit 2 the middle button. All seven non-zero combinations are reported as given.
- R5: In stream mode with `autospeed` high, a `sample_tick` loads each report register with the remapped accumulator value and raises `rep_valid` for one cycle. The remap of magnitude m is 0→0, 1→1, 2→1, 3→3, 4→6, 5→9, and 2·m for m≥6.
- R6: The remap keeps the sign and works on the magnitude only. A result above the limit is clipped to +255 for positive values and to -256 for negative values.
- R7: In stream mode with `autospeed` low, a tick loads the accumulator values linearly. Between ticks the report registers hold their values and `rep_valid` is 0.
- R8: In remote mode `sample_tick` has no effect and `rep_valid` stays 0. `mot_x`/`mot_y` show the accumulator values of the previous cycle, without remapping.
- R9: A `cmd_clr` or `rpt_sent` pulse clears both accumulators and both overflow flags at the next edge. The clear takes priority over a step in the same cycle.
- R10: While `resend_pend` is high, requested clears do not act and are remembered. They take effect at the first edge at which `resend_pend` is low.
- R11: After reset the accumulators, overflow flags, buttons, report registers and `rep_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sens_up | input | 1 | Up direction sensor, synchronized |
| sens_dn | input | 1 | Down direction sensor, synchronized |
| sens_lt | input | 1 | Left direction sensor, synchronized |
| sens_rt | input | 1 | Right direction sensor, synchronized |
| btn_raw | input | NBTN | Raw buttons: bit 0 left, 1 right, 2 middle |
| stream_mode | input | 1 | 1 = stream, 0 = remote |
| autospeed | input | 1 | 1 = apply magnitude remap in stream mode |
| sample_tick | input | 1 | End of sample interval strobe |
| cmd_clr | input | 1 | A non-resend command was received |
| rpt_sent | input | 1 | A movement report finished transmission |
| resend_pend | input | 1 | Resend of last packet outstanding; defer clears |
| mot_x | output | W | Reported X movement, two's complement |
| mot_y | output | W | Reported Y movement, two's complement |
| ovf_x | output | 1 | X accumulator overflow flag |
| ovf_y | output | 1 | Y accumulator overflow flag |
| btn | output | NBTN | Debounced button state |
| rep_valid | output | 1 | One-cycle pulse when a stream snapshot is loaded |

## Verification
The counting path runs under a seeded random mix of sensor changes on all four lines, clear strobes and resend holds in remote mode. There the one-cycle-late report exposes each accumulator, and the mix separates single steps, cancelling opposing steps and deferred clears. Long runs in one direction drive both saturation limits to check the clipping and the sticky overflow flags. Stream snapshots of magnitudes 0 to 7, of negative values and of values large enough to clip tell the table entries apart from the doubling rule, from the linear path and from the sign handling. Button levels are held one cycle short of the debounce time and then exactly that long, for every combination and for releases.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;

    // Stepped acceleration curve applied to a movement magnitude.
    function automatic int unsigned remap_mag(input int unsigned m);
        int unsigned r;
        case (m)
            0:       r = 0;
            1:       r = 1;
            2:       r = 1;
            3:       r = 3;
            4:       r = 6;
            5:       r = 9;
            default: r = 2 * m;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mc_debounce.sv
`timescale 1ns/1ps
module mc_debounce #(
    parameter int CNT = 420
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic stable
);
    localparam int CW = $clog2(CNT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          st;
    } db_t;

    db_t db_d, db_q;

    always_comb begin
        db_d = db_q;
        if (raw == db_q.st) begin
            db_d.cnt = '0;
        end else if (db_q.cnt == CW'(CNT - 1)) begin
            db_d.st  = raw;
            db_d.cnt = '0;
        end else begin
            db_d.cnt = db_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) db_q <= '0;
        else        db_q <= db_d;
    end

    assign stable = db_q.st;

    // R3: a raw level equal to the debounced one never moves it
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (raw == db_q.st) |=> $stable(db_q.st));

endmodule

// File: rtl/mc_axis_acc.sv
`timescale 1ns/1ps
module mc_axis_acc #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    input  logic         clr,
    output logic [W-1:0] acc,
    output logic         ovf
);
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        logic [W-1:0] acc;
        logic         ovf;
    } ax_t;

    ax_t ax_d, ax_q;

    always_comb begin
        ax_d = ax_q;
        if (clr) begin
            ax_d = '0;
        end else if (inc && !dec) begin
            if (ax_q.acc == MAXV) ax_d.ovf = 1'b1;
            else                  ax_d.acc = ax_q.acc + 1'b1;
        end else if (dec && !inc) begin
            if (ax_q.acc == MINV) ax_d.ovf = 1'b1;
            else                  ax_d.acc = ax_q.acc - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ax_q <= '0;
        else        ax_q <= ax_d;
    end

    assign acc = ax_q.acc;
    assign ovf = ax_q.ovf;

    // R1: an up step below the limit moves the count by exactly one
    p_step_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && !dec && ax_q.acc != MAXV) |=> (ax_q.acc == W'($past(ax_q.acc) + 1'b1)));

    // R2: saturation at the upper limit with the flag raised
    p_sat_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && !dec && ax_q.acc == MAXV) |=> (ax_q.acc == MAXV && ax_q.ovf));

    // R2: overflow flag is sticky until a clear
    p_ovf_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ax_q.ovf && !clr) |=> ax_q.ovf);

    // R9: a clear empties the axis
    p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ax_q.acc == '0 && !ax_q.ovf));

endmodule

// File: rtl/mc_motion_top.sv
`timescale 1ns/1ps
module mc_motion_top #(
    parameter int W          = 9,
    parameter int DEB_CYCLES = 420,
    parameter int NBTN       = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sens_up,
    input  logic            sens_dn,
    input  logic            sens_lt,
    input  logic            sens_rt,
    input  logic [NBTN-1:0] btn_raw,
    input  logic            stream_mode,
    input  logic            autospeed,
    input  logic            sample_tick,
    input  logic            cmd_clr,
    input  logic            rpt_sent,
    input  logic            resend_pend,
    output logic [W-1:0]    mot_x,
    output logic [W-1:0]    mot_y,
    output logic            ovf_x,
    output logic            ovf_y,
    output logic [NBTN-1:0] btn,
    output logic            rep_valid
);
    localparam int NSENS = 4;

    typedef struct packed {
        logic [NSENS-1:0] prev;   // {up, dn, lt, rt}
        logic             pend;
        logic [W-1:0]     rx;
        logic [W-1:0]     ry;
        logic             vld;
    } top_t;

    top_t st_d, st_q;

    logic [NSENS-1:0] sens_now;
    logic [NSENS-1:0] tg;
    logic             clr_eff;
    logic [W-1:0]     acc_x, acc_y;

    function automatic logic [W-1:0] speed_map(input logic [W-1:0] v);
        int unsigned mag, res, lim;
        mag = v[W-1] ? ((32'd1 << W) - 32'(v)) : 32'(v);
        res = mc_pkg::remap_mag(mag);
        lim = v[W-1] ? (32'd1 << (W - 1)) : ((32'd1 << (W - 1)) - 32'd1);
        if (res > lim) res = lim;
        return v[W-1] ? W'((32'd1 << W) - res) : W'(res);
    endfunction

    assign sens_now = {sens_up, sens_dn, sens_lt, sens_rt};
    assign tg       = sens_now ^ st_q.prev;
    assign clr_eff  = (cmd_clr | rpt_sent | st_q.pend) & ~resend_pend;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sens_now;
        st_d.pend = resend_pend & (st_q.pend | cmd_clr | rpt_sent);
        if (stream_mode) begin
            st_d.vld = sample_tick;
            if (sample_tick) begin
                st_d.rx = autospeed ? speed_map(acc_x) : acc_x;
                st_d.ry = autospeed ? speed_map(acc_y) : acc_y;
            end
        end else begin
            st_d.vld = 1'b0;
            st_d.rx  = acc_x;
            st_d.ry  = acc_y;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    mc_axis_acc #(.W(W)) u_ax_x (
        .clk(clk), .rst_n(rst_n), .inc(tg[0]), .dec(tg[1]), .clr(clr_eff),
        .acc(acc_x), .ovf(ovf_x)
    );

    mc_axis_acc #(.W(W)) u_ax_y (
        .clk(clk), .rst_n(rst_n), .inc(tg[3]), .dec(tg[2]), .clr(clr_eff),
        .acc(acc_y), .ovf(ovf_y)
    );

    for (genvar gi = 0; gi < NBTN; gi++) begin : g_btn
        mc_debounce #(.CNT(DEB_CYCLES)) u_db (
            .clk(clk), .rst_n(rst_n), .raw(btn_raw[gi]), .stable(btn[gi])
        );
    end

    assign mot_x     = st_q.rx;
    assign mot_y     = st_q.ry;
    assign rep_valid = st_q.vld;

    // R5: a stream tick produces a valid pulse
    p_tick_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stream_mode && sample_tick) |=> rep_valid);

    // R8: remote mode never flags a report
    p_remote_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !stream_mode |=> !rep_valid);

    // R8: remote report follows the accumulator one cycle late
    p_remote_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !stream_mode |=> (mot_x == $past(acc_x) && mot_y == $past(acc_y)));

    // R10: with a resend outstanding and no motion, counts do not move
    p_hold_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (resend_pend && tg == '0) |=> ($stable(acc_x) && $stable(acc_y)));

endmodule

// File: tb/mc_motion_top_tb.sv
`timescale 1ns/1ps
module mc_motion_top_tb;
    localparam int W   = 9;
    localparam int DEB = 420;
    localparam int NB  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s_up = 0, s_dn = 0, s_lt = 0, s_rt = 0;
    logic [NB-1:0] braw = '0;
    logic strm = 0, aspd = 0, tick = 0, cclr = 0, rsent = 0, rpend = 0;
    logic [W-1:0] mot_x, mot_y;
    logic ovf_x, ovf_y, rep_valid;
    logic [NB-1:0] btn;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // model state
    int ex = 0, ey = 0, erx = 0, ery = 0;
    bit eovx = 0, eovy = 0, epend = 0;
    logic p_up = 0, p_dn = 0, p_lt = 0, p_rt = 0;

    always #2.5 clk = ~clk;

    mc_motion_top #(.W(W), .DEB_CYCLES(DEB), .NBTN(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .sens_up(s_up), .sens_dn(s_dn),
        .sens_lt(s_lt), .sens_rt(s_rt), .btn_raw(braw), .stream_mode(strm),
        .autospeed(aspd), .sample_tick(tick), .cmd_clr(cclr), .rpt_sent(rsent),
        .resend_pend(rpend), .mot_x(mot_x), .mot_y(mot_y), .ovf_x(ovf_x),
        .ovf_y(ovf_y), .btn(btn), .rep_valid(rep_valid)
    );

    function automatic int exp_conv(input int v);
        int m, r;
        m = (v < 0) ? -v : v;
        case (m)
            0: r = 0; 1: r = 1; 2: r = 1; 3: r = 3; 4: r = 6; 5: r = 9;
            default: r = 2 * m;
        endcase
        if (v < 0) begin
            if (r > 256) r = 256;
            return -r;
        end
        if (r > 255) r = 255;
        return r;
    endfunction

    function automatic int step_axis(input int v, input bit pos, input bit neg, inout bit ov);
        if (pos && !neg) begin
            if (v == 255) ov = 1; else v = v + 1;
        end else if (neg && !pos) begin
            if (v == -256) ov = 1; else v = v - 1;
        end
        return v;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one clock: advance model with the current inputs, then wait past the edge
    task automatic cyc();
        bit clr;
        if (!strm) begin
            erx = ex; ery = ey;
        end else if (tick) begin
            erx = aspd ? exp_conv(ex) : ex;
            ery = aspd ? exp_conv(ey) : ey;
        end
        clr = (cclr || rsent || epend) && !rpend;
        epend = rpend && (epend || cclr || rsent);
        if (clr) begin
            ex = 0; ey = 0; eovx = 0; eovy = 0;
        end else begin
            ex = step_axis(ex, s_rt ^ p_rt, s_lt ^ p_lt, eovx);
            ey = step_axis(ey, s_up ^ p_up, s_dn ^ p_dn, eovy);
        end
        p_up = s_up; p_dn = s_dn; p_lt = s_lt; p_rt = s_rt;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_state(input string req);
        chk(req, "mot_x", int'($signed(mot_x)), erx);
        chk(req, "mot_y", int'($signed(mot_y)), ery);
        chk(req, "ovf_x", int'(ovf_x), int'(eovx));
        chk(req, "ovf_y", int'(ovf_y), int'(eovy));
    endtask

    task automatic clear_all();
        cclr = 1; cyc(); cclr = 0;
    endtask

    task automatic load_x(input int v);
        clear_all();
        for (int i = 0; i < ((v < 0) ? -v : v); i++) begin
            if (v > 0) s_rt = ~s_rt; else s_lt = ~s_lt;
            cyc();
        end
        cyc();
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R11: reset state
        chk("R11", "mot_x", int'(mot_x), 0);
        chk("R11", "ovf_x|ovf_y", int'(ovf_x | ovf_y), 0);
        chk("R11", "btn", int'(btn), 0);
        chk("R11", "rep_valid", int'(rep_valid), 0);

        // R1: opposing changes in one cycle cancel
        s_rt = 1; s_lt = 1; cyc(); cyc();
        chk("R1", "cancel x", int'($signed(mot_x)), 0);
        s_up = 1; cyc(); cyc();
        chk("R1", "single up", int'($signed(mot_y)), 1);

        // R1 R9 R10: random movement with clears and resend holds in remote mode
        for (int i = 0; i < 3000; i++) begin
            s_up = s_up ^ ($urandom_range(0, 2) == 0);
            s_dn = s_dn ^ ($urandom_range(0, 2) == 0);
            s_lt = s_lt ^ ($urandom_range(0, 2) == 0);
            s_rt = s_rt ^ ($urandom_range(0, 2) == 0);
            cclr  = ($urandom_range(0, 15) == 0);
            rsent = ($urandom_range(0, 15) == 0);
            if ($urandom_range(0, 7) == 0) rpend = ~rpend;
            tick  = ($urandom_range(0, 3) == 0);
            cyc();
            chk_state("R1/R9/R10");
            chk("R8", "rep_valid remote", int'(rep_valid), 0);
        end
        cclr = 0; rsent = 0; rpend = 0; tick = 0;
        cyc(); cyc();
        chk_state("R10");

        // R2: saturation at both limits
        load_x(0);
        for (int i = 0; i < 260; i++) begin s_rt = ~s_rt; cyc(); end
        cyc();
        chk("R2", "x high sat", int'($signed(mot_x)), 255);
        chk("R2", "ovf_x", int'(ovf_x), 1);
        for (int i = 0; i < 520; i++) begin s_lt = ~s_lt; cyc(); end
        cyc();
        chk("R2", "x low sat", int'($signed(mot_x)), -256);
        chk("R2", "ovf_x sticky", int'(ovf_x), 1);

        // R10: clear deferred while resend pending
        rpend = 1; cclr = 1; cyc(); cclr = 0; cyc(); cyc();
        chk("R10", "ovf_x held", int'(ovf_x), 1);
        chk("R10", "x held", int'($signed(mot_x)), -256);
        rpend = 0; cyc(); cyc();
        chk("R10", "x after release", int'($signed(mot_x)), 0);
        chk("R9", "ovf_x cleared", int'(ovf_x), 0);

        // R9: clear beats a same-cycle step
        s_rt = ~s_rt; rsent = 1; cyc(); rsent = 0; cyc();
        chk("R9", "clear priority", int'($signed(mot_x)), 0);

        // R5 R6 R7: stream snapshots
        begin
            int vals[14] = '{0, 1, 2, 3, 4, 5, 6, 7, 100, -3, -5, -6, 200, -200};
            foreach (vals[k]) begin
                load_x(vals[k]);
                strm = 1; aspd = 1; tick = 1; cyc(); tick = 0;
                chk("R5/R6", "remap x", int'($signed(mot_x)), exp_conv(vals[k]));
                chk("R5", "valid on tick", int'(rep_valid), 1);
                s_rt = ~s_rt; cyc();
                chk("R7", "hold between ticks", int'($signed(mot_x)), exp_conv(vals[k]));
                chk("R7", "valid low", int'(rep_valid), 0);
                aspd = 0; tick = 1; cyc(); tick = 0;
                chk("R7", "linear x", int'($signed(mot_x)), (vals[k] == 255) ? 255 : vals[k] + 1);
                strm = 0; cyc();
            end
        end
        chk("R6", "literal -200", exp_conv(-200), -256);
        chk_state("R8");

        // R3 R4: debounce of every combination, press and release
        for (int c = 1; c < 8; c++) begin
            braw = NB'(c);
            repeat (DEB - 1) cyc();
            chk("R3", "before debounce", int'(btn), 0);
            cyc();
            chk("R4", "combination", int'(btn), c);
            braw = '0;
            repeat (DEB - 1) cyc();
            chk("R3", "release early", int'(btn), c);
            cyc();
            chk("R3", "release", int'(btn), 0);
        end
        // R3: short glitch ignored
        braw = 3'b101; repeat (DEB - 1) cyc();
        braw = 3'b000; repeat (DEB + 2) cyc();
        chk("R3", "glitch ignored", int'(btn), 0);

        done = 1;
        summary();
        $finish;
    end
endmodule